// File: doc/BRIEF.md
# Serial-Programmed Multi-Channel DAC Register Controller

This block is the digital register side of a multi-channel digital-to-analog converter that is programmed over a serial peripheral port. A host shifts 32-bit command words into it, most significant bit first, while holding the chip-select low. When the chip-select goes high after exactly 32 serial clocks, the word is decoded. Each channel has two stages of storage: a staging (input) register and an output (active) register. Commands load the staging stage, copy it into the active stage, or do both. A separate command powers channels down through a bitmask and selects a termination mode for them. Other commands set two configuration bits, load a per-channel hold mask, zero all codes or reset the whole block.

The serial pins are sampled in the system clock domain. The block drives the active code, the power-down flag and the stored termination mode of every channel to the analog side, together with an internal-reference enable and a chain-mode enable. The channel count (1 to 8) and the code width (8 to 16 bits) are parameters. A code sits left-justified in the 20-bit payload, so its shift is 20 minus the code width.

Top module: `dacreg_ctrl`

## Requirements
- R1: A word is acted on only when CS_N rises after exactly 32 rising SCLK edges. Bits are taken MSB first on SCLK rising edges. After any other count, no output or register changes. An accepted word shows at the outputs within 8 clk cycles of the CS_N rise.
- R2: Bits 27:24 of the word hold the command and bits 23:20 hold the address. The code is payload bits [19 : 20-CODE_W] (for CODE_W=12, bits 19:8).
- R3: Command 0 loads the staging register of the addressed channel with the code. The active codes do not change.
- R4: Command 1 copies the addressed channel's staging register into its active register.
- R5: Command 2 loads the addressed staging register, then copies staging into active on every channel.
- R6: Command 3 loads the addressed channel's staging and active registers with the code. The hold mask has no effect on this command.
- R7: Address 15 selects all channels. An address from NUM_CH to 14 selects none: commands 0, 1 and 3 change nothing, and command 2 loads no staging register but still does its all-channel copy.
- R8: Command 4 ignores the address. Payload bits [NUM_CH-1:0] select channels and bits 9:8 give the mode (0 normal, 1 low-ohm, 2 high-ohm, 3 open). Mode 0 clears the power-down flag of the selected channels and keeps their stored mode. Modes 1 to 3 set the flag and store the mode. Unselected channels are unchanged.
- R9: Command 5 zeroes every staging and active register.
- R10: Command 6 loads the hold mask from payload bits [NUM_CH-1:0]. A channel whose hold bit is set ignores the copy of commands 1 and 2.
- R11: Reset from rst_n or from command 7 does the following: every staging and active register gets the midscale code (only the MSB set), all power-down flags clear, every stored mode becomes 1, and the configuration bits and hold mask clear.
- R12: Command 8 writes the configuration: payload bit 0 drives ref_int_en and bit 1 drives chain_en.
- R13: Commands 9 to 15 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; serial pins are oversampled on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_mosi | input | 1 | Serial data from the host |
| dac_code | output | NUM_CH*CODE_W | Active code of each channel, channel 0 in the low bits |
| dac_pd | output | NUM_CH | Power-down flag of each channel |
| dac_pd_mode | output | 2*NUM_CH | Stored termination mode of each channel, two bits each |
| ref_int_en | output | 1 | Internal reference enable |
| chain_en | output | 1 | Chain-mode enable |

## Verification
The bench builds the block with four channels and a 12-bit code. This puts the code field at payload bits 19:8 rather than the default position, so a wrong shift is caught. It also leaves addresses 4 to 14 as valid-looking addresses that select no channel. With only four channels, the broadcast address, partial power-down masks and the hold mask all produce mixes of affected and unaffected channels that can be checked one by one. Truncated and over-long frames are sent to confirm that only a 32-clock frame is ever acted on.

// File: rtl/dacreg_pkg.sv
package dacreg_pkg;
   localparam int FRAME_BITS = 32;
   localparam int KEEP_BITS  = 28;
   localparam int PAY_W      = 20;
   localparam int CNT_W      = 6;
   localparam logic [3:0] ADDR_ALL = 4'hF;

   localparam logic [3:0] OP_WR_STAGE   = 4'd0;
   localparam logic [3:0] OP_COPY       = 4'd1;
   localparam logic [3:0] OP_WR_COPYALL = 4'd2;
   localparam logic [3:0] OP_WR_BOTH    = 4'd3;
   localparam logic [3:0] OP_POWER      = 4'd4;
   localparam logic [3:0] OP_ZERO       = 4'd5;
   localparam logic [3:0] OP_HOLD       = 4'd6;
   localparam logic [3:0] OP_SRESET     = 4'd7;
   localparam logic [3:0] OP_CONFIG     = 4'd8;

   localparam logic [1:0] TERM_NONE = 2'd0;
   localparam logic [1:0] TERM_LOW  = 2'd1;

   typedef struct packed {
      logic [3:0]       op;
      logic [3:0]       addr;
      logic [PAY_W-1:0] pay;
   } word_t;
endpackage

// File: rtl/dacreg_spi_rx.sv
module dacreg_spi_rx
   import dacreg_pkg::*;
(
   input  logic  clk,
   input  logic  rst_n,
   input  logic  sclk,
   input  logic  cs_n,
   input  logic  mosi,
   output logic  word_vld,
   output word_t word_q
);
   logic [2:0]           sclk_q;
   logic [2:0]           cs_q;
   logic [1:0]           mosi_q;
   logic [KEEP_BITS-1:0] shreg;
   logic [CNT_W-1:0]     cnt;
   logic                 sclk_rise;
   logic                 cs_rise;
   logic                 selected;

   assign sclk_rise = sclk_q[1] & ~sclk_q[2];
   assign cs_rise   = cs_q[1] & ~cs_q[2];
   assign selected  = ~cs_q[1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sclk_q <= '0;
         cs_q   <= '1;
         mosi_q <= '0;
      end else begin
         sclk_q <= {sclk_q[1:0], sclk};
         cs_q   <= {cs_q[1:0], cs_n};
         mosi_q <= {mosi_q[0], mosi};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         shreg <= '0;
         cnt   <= '0;
      end else if (!selected) begin
         cnt <= '0;
      end else if (sclk_rise) begin
         shreg <= {shreg[KEEP_BITS-2:0], mosi_q[1]};
         if (cnt != '1) cnt <= cnt + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         word_vld <= 1'b0;
         word_q   <= '0;
      end else begin
         word_vld <= cs_rise && (cnt == CNT_W'(FRAME_BITS));
         if (cs_rise) word_q <= word_t'(shreg);
      end
   end
endmodule

// File: rtl/dacreg_decode.sv
module dacreg_decode
   import dacreg_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int CODE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              word_vld,
   input  word_t             word_q,
   output logic [NUM_CH-1:0] ld_stage,
   output logic [NUM_CH-1:0] ld_active,
   output logic [NUM_CH-1:0] pd_on,
   output logic [NUM_CH-1:0] pd_off,
   output logic [CODE_W-1:0] code,
   output logic [1:0]        term,
   output logic              zero_all,
   output logic              soft_rst,
   output logic              ref_int_en,
   output logic              chain_en
);
   localparam int CODE_LSB = PAY_W - CODE_W;

   logic [NUM_CH-1:0] sel;
   logic [NUM_CH-1:0] hold;
   logic [NUM_CH-1:0] mask;

   for (genvar i = 0; i < NUM_CH; i++) begin : g_sel
      assign sel[i] = (word_q.addr == ADDR_ALL) || (word_q.addr == 4'(i));
   end

   assign code     = word_q.pay[PAY_W-1:CODE_LSB];
   assign term     = word_q.pay[9:8];
   assign mask     = word_q.pay[NUM_CH-1:0];
   assign zero_all = word_vld && (word_q.op == OP_ZERO);
   assign soft_rst = word_vld && (word_q.op == OP_SRESET);

   always_comb begin
      ld_stage  = '0;
      ld_active = '0;
      pd_on     = '0;
      pd_off    = '0;
      if (word_vld) begin
         unique case (word_q.op)
            OP_WR_STAGE:   ld_stage = sel;
            OP_COPY:       ld_active = sel & ~hold;
            OP_WR_COPYALL: begin
               ld_stage  = sel;
               ld_active = ~hold;
            end
            OP_WR_BOTH: begin
               ld_stage  = sel;
               ld_active = sel;
            end
            OP_POWER: begin
               if (term == TERM_NONE) pd_off = mask;
               else                   pd_on  = mask;
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold       <= '0;
         ref_int_en <= 1'b0;
         chain_en   <= 1'b0;
      end else if (soft_rst) begin
         hold       <= '0;
         ref_int_en <= 1'b0;
         chain_en   <= 1'b0;
      end else if (word_vld) begin
         if (word_q.op == OP_HOLD) hold <= mask;
         if (word_q.op == OP_CONFIG) begin
            ref_int_en <= word_q.pay[0];
            chain_en   <= word_q.pay[1];
         end
      end
   end
endmodule

// File: rtl/dacreg_chan.sv
module dacreg_chan
   import dacreg_pkg::*;
#(
   parameter int CODE_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              soft_rst,
   input  logic              zero_all,
   input  logic              ld_stage,
   input  logic              ld_active,
   input  logic              pd_on,
   input  logic              pd_off,
   input  logic [CODE_W-1:0] code,
   input  logic [1:0]        term,
   output logic [CODE_W-1:0] active,
   output logic              pd,
   output logic [1:0]        pd_mode
);
   localparam logic [CODE_W-1:0] MIDSCALE = {1'b1, {(CODE_W-1){1'b0}}};

   logic [CODE_W-1:0] stage;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stage   <= MIDSCALE;
         active  <= MIDSCALE;
         pd      <= 1'b0;
         pd_mode <= TERM_LOW;
      end else if (soft_rst) begin
         stage   <= MIDSCALE;
         active  <= MIDSCALE;
         pd      <= 1'b0;
         pd_mode <= TERM_LOW;
      end else if (zero_all) begin
         stage  <= '0;
         active <= '0;
      end else begin
         if (ld_stage)  stage  <= code;
         if (ld_active) active <= ld_stage ? code : stage;
         if (pd_on) begin
            pd      <= 1'b1;
            pd_mode <= term;
         end
         if (pd_off) pd <= 1'b0;
      end
   end
endmodule

// File: rtl/dacreg_ctrl.sv
module dacreg_ctrl
   import dacreg_pkg::*;
#(
   parameter int NUM_CH = 8,
   parameter int CODE_W = 16
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     spi_sclk,
   input  logic                     spi_cs_n,
   input  logic                     spi_mosi,
   output logic [NUM_CH*CODE_W-1:0] dac_code,
   output logic [NUM_CH-1:0]        dac_pd,
   output logic [2*NUM_CH-1:0]      dac_pd_mode,
   output logic                     ref_int_en,
   output logic                     chain_en
);
   if (CODE_W < 8 || CODE_W > 16) begin : g_bad_code_w
      $error("dacreg_ctrl: CODE_W must lie in 8..16");
   end
   if (NUM_CH < 1 || NUM_CH > 8) begin : g_bad_num_ch
      $error("dacreg_ctrl: NUM_CH must lie in 1..8");
   end

   logic              word_vld;
   word_t             word_q;
   logic [NUM_CH-1:0] ld_stage;
   logic [NUM_CH-1:0] ld_active;
   logic [NUM_CH-1:0] pd_on;
   logic [NUM_CH-1:0] pd_off;
   logic [CODE_W-1:0] code;
   logic [1:0]        term;
   logic              zero_all;
   logic              soft_rst;

   dacreg_spi_rx u_rx (
      .clk      (clk),
      .rst_n    (rst_n),
      .sclk     (spi_sclk),
      .cs_n     (spi_cs_n),
      .mosi     (spi_mosi),
      .word_vld (word_vld),
      .word_q   (word_q)
   );

   dacreg_decode #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_dec (
      .clk        (clk),
      .rst_n      (rst_n),
      .word_vld   (word_vld),
      .word_q     (word_q),
      .ld_stage   (ld_stage),
      .ld_active  (ld_active),
      .pd_on      (pd_on),
      .pd_off     (pd_off),
      .code       (code),
      .term       (term),
      .zero_all   (zero_all),
      .soft_rst   (soft_rst),
      .ref_int_en (ref_int_en),
      .chain_en   (chain_en)
   );

   for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
      dacreg_chan #(.CODE_W(CODE_W)) u_ch (
         .clk       (clk),
         .rst_n     (rst_n),
         .soft_rst  (soft_rst),
         .zero_all  (zero_all),
         .ld_stage  (ld_stage[i]),
         .ld_active (ld_active[i]),
         .pd_on     (pd_on[i]),
         .pd_off    (pd_off[i]),
         .code      (code),
         .term      (term),
         .active    (dac_code[i*CODE_W +: CODE_W]),
         .pd        (dac_pd[i]),
         .pd_mode   (dac_pd_mode[2*i +: 2])
      );
   end
endmodule

// File: rtl/dacreg_ctrl_chk.sv
module dacreg_ctrl_chk #(
   parameter int NUM_CH = 8,
   parameter int CODE_W = 16
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     word_vld,
   input logic [3:0]               op,
   input logic [1:0]               term,
   input logic [NUM_CH-1:0]        mask,
   input logic [1:0]               cfg_bits,
   input logic [NUM_CH*CODE_W-1:0] dac_code,
   input logic [NUM_CH-1:0]        dac_pd,
   input logic                     ref_int_en,
   input logic                     chain_en
);
   assert_no_change_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !word_vld |=> ($stable(dac_code) && $stable(dac_pd)));

   assert_unused_op_R13: assert property (@(posedge clk) disable iff (!rst_n)
      (word_vld && op >= 4'd9) |=> ($stable(dac_code) && $stable(dac_pd)
                                    && $stable(ref_int_en) && $stable(chain_en)));

   assert_zero_all_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (word_vld && op == 4'd5) |=> (dac_code == '0));

   assert_pd_set_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (word_vld && op == 4'd4 && term != 2'd0) |=> ((dac_pd & $past(mask)) == $past(mask)));

   assert_config_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (word_vld && op == 4'd8) |=> ({chain_en, ref_int_en} == $past(cfg_bits)));

   assert_soft_reset_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (word_vld && op == 4'd7) |=> (dac_pd == '0));
endmodule

bind dacreg_ctrl dacreg_ctrl_chk #(.NUM_CH(NUM_CH), .CODE_W(CODE_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .word_vld   (word_vld),
   .op         (word_q.op),
   .term       (word_q.pay[9:8]),
   .mask       (word_q.pay[NUM_CH-1:0]),
   .cfg_bits   (word_q.pay[1:0]),
   .dac_code   (dac_code),
   .dac_pd     (dac_pd),
   .ref_int_en (ref_int_en),
   .chain_en   (chain_en)
);

// File: tb/dacreg_ctrl_test.sv
module dacreg_ctrl_test;
   localparam int NCH = 4;
   localparam int CW  = 12;
   localparam logic [CW-1:0] MID = {1'b1, {(CW-1){1'b0}}};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic sclk = 1'b0;
   logic cs_n = 1'b1;
   logic mosi = 1'b0;
   logic [NCH*CW-1:0] dac_code;
   logic [NCH-1:0]    dac_pd;
   logic [2*NCH-1:0]  dac_pd_mode;
   logic              ref_int_en;
   logic              chain_en;

   int checks = 0;
   int errors = 0;

   logic [CW-1:0]  m_stage [NCH];
   logic [CW-1:0]  m_act   [NCH];
   logic [NCH-1:0] m_pd;
   logic [1:0]     m_mode  [NCH];
   logic [NCH-1:0] m_hold;
   logic [1:0]     m_cfg;

   always #5 clk = ~clk;

   dacreg_ctrl #(.NUM_CH(NCH), .CODE_W(CW)) uut (
      .clk         (clk),
      .rst_n       (rst_n),
      .spi_sclk    (sclk),
      .spi_cs_n    (cs_n),
      .spi_mosi    (mosi),
      .dac_code    (dac_code),
      .dac_pd      (dac_pd),
      .dac_pd_mode (dac_pd_mode),
      .ref_int_en  (ref_int_en),
      .chain_en    (chain_en)
   );

   function automatic logic [31:0] mk(input int op, input int addr, input int pay);
      return {4'h0, 4'(op), 4'(addr), 20'(pay)};
   endfunction

   task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   task automatic model_reset();
      for (int c = 0; c < NCH; c++) begin
         m_stage[c] = MID;
         m_act[c]   = MID;
         m_mode[c]  = 2'd1;
      end
      m_pd   = '0;
      m_hold = '0;
      m_cfg  = '0;
   endtask

   task automatic model_apply(input logic [31:0] w);
      logic [3:0]    op;
      logic [3:0]    addr;
      logic [19:0]   pay;
      logic [CW-1:0] code;
      op   = w[27:24];
      addr = w[23:20];
      pay  = w[19:0];
      code = pay[19 -: CW];
      case (op)
         4'd0: for (int c = 0; c < NCH; c++) if (addr == 15 || addr == c) m_stage[c] = code;
         4'd1: for (int c = 0; c < NCH; c++)
                  if ((addr == 15 || addr == c) && !m_hold[c]) m_act[c] = m_stage[c];
         4'd2: begin
            for (int c = 0; c < NCH; c++) if (addr == 15 || addr == c) m_stage[c] = code;
            for (int c = 0; c < NCH; c++) if (!m_hold[c]) m_act[c] = m_stage[c];
         end
         4'd3: for (int c = 0; c < NCH; c++)
                  if (addr == 15 || addr == c) begin
                     m_stage[c] = code;
                     m_act[c]   = code;
                  end
         4'd4: for (int c = 0; c < NCH; c++)
                  if (pay[c]) begin
                     if (pay[9:8] == 2'd0) m_pd[c] = 1'b0;
                     else begin
                        m_pd[c]   = 1'b1;
                        m_mode[c] = pay[9:8];
                     end
                  end
         4'd5: for (int c = 0; c < NCH; c++) begin
                  m_stage[c] = '0;
                  m_act[c]   = '0;
               end
         4'd6: m_hold = pay[NCH-1:0];
         4'd7: model_reset();
         4'd8: m_cfg = pay[1:0];
         default: ;
      endcase
   endtask

   task automatic send(input logic [31:0] w, input int nbits, input bit apply);
      @(negedge clk) cs_n = 1'b0;
      repeat (4) @(negedge clk);
      for (int b = 0; b < nbits; b++) begin
         mosi = (b < 32) ? w[31-b] : 1'b0;
         repeat (4) @(negedge clk);
         sclk = 1'b1;
         repeat (4) @(negedge clk);
         sclk = 1'b0;
      end
      repeat (4) @(negedge clk);
      cs_n = 1'b1;
      repeat (8) @(negedge clk);
      if (apply && nbits == 32) model_apply(w);
   endtask

   task automatic check_state(input string tag);
      logic [2*NCH-1:0] modes;
      for (int c = 0; c < NCH; c++) begin
         check($sformatf("%s ch%0d code", tag, c), 32'(dac_code[c*CW +: CW]), 32'(m_act[c]));
         modes[2*c +: 2] = m_mode[c];
      end
      check($sformatf("%s pd", tag), 32'(dac_pd), 32'(m_pd));
      check($sformatf("%s mode", tag), 32'(dac_pd_mode), 32'(modes));
      check($sformatf("%s cfg", tag), {30'd0, chain_en, ref_int_en}, {30'd0, m_cfg});
   endtask

   task automatic t_reset();
      model_reset();
      check_state("R11 pin reset");
   endtask

   task automatic t_write_update();
      send(mk(0, 1, 20'hABC00), 32, 1);
      check_state("R3 stage only");
      send(mk(1, 1, 0), 32, 1);
      check_state("R4 copy ch1");
      send(mk(3, 2, 20'h12300), 32, 1);
      check_state("R2 R6 write both ch2");
      send(mk(0, 3, 20'h44400), 32, 1);
      send(mk(2, 0, 20'h7FF00), 32, 1);
      check_state("R5 write and copy all");
   endtask

   task automatic t_broadcast();
      send(mk(0, 15, 20'h55500), 32, 1);
      check_state("R7 broadcast stage");
      send(mk(1, 15, 0), 32, 1);
      check_state("R7 broadcast copy");
      send(mk(3, 6, 20'hFFF00), 32, 1);
      check_state("R7 unmapped address");
      send(mk(0, 2, 20'h99900), 32, 1);
      send(mk(2, 9, 20'h33300), 32, 1);
      check_state("R7 unmapped address copy all");
   endtask

   task automatic t_bad_frames();
      send(mk(3, 0, 20'hEEE00), 31, 0);
      check_state("R1 31 clocks");
      send(mk(3, 0, 20'hEEE00), 33, 0);
      check_state("R1 33 clocks");
      send(mk(8, 0, 3), 0, 0);
      check_state("R1 no clocks");
   endtask

   task automatic t_power();
      send(mk(4, 3, 20'h00205), 32, 1);
      check_state("R8 mode 2 mask 0101");
      send(mk(4, 0, 20'h00302), 32, 1);
      check_state("R8 mode 3 mask 0010");
      send(mk(4, 7, 20'h00001), 32, 1);
      check_state("R8 normal mask 0001");
   endtask

   task automatic t_hold();
      send(mk(6, 0, 20'h00002), 32, 1);
      send(mk(0, 1, 20'h11100), 32, 1);
      send(mk(1, 1, 0), 32, 1);
      check_state("R10 hold blocks copy");
      send(mk(2, 0, 20'h22200), 32, 1);
      check_state("R10 hold blocks copy all");
      send(mk(3, 1, 20'hCCC00), 32, 1);
      check_state("R6 write both ignores hold");
      send(mk(6, 0, 0), 32, 1);
      send(mk(1, 15, 0), 32, 1);
      check_state("R10 hold released");
   endtask

   task automatic t_config();
      send(mk(8, 0, 3), 32, 1);
      check_state("R12 both bits");
      send(mk(8, 5, 1), 32, 1);
      check_state("R12 reference only");
   endtask

   task automatic t_ignored();
      send(mk(8, 0, 2), 32, 1);
      for (int op = 9; op < 16; op++) begin
         send(mk(op, 1, 20'hFFFFF), 32, 1);
         check_state($sformatf("R13 op %0d", op));
      end
   endtask

   task automatic t_zero_and_reset();
      send(mk(5, 2, 0), 32, 1);
      check_state("R9 zero all");
      send(mk(4, 0, 20'h0030F), 32, 1);
      send(mk(6, 0, 20'h0000F), 32, 1);
      send(mk(7, 0, 0), 32, 1);
      check_state("R11 command reset");
      send(mk(0, 0, 20'h0AB00), 32, 1);
      send(mk(1, 0, 0), 32, 1);
      check_state("R11 hold mask cleared");
   endtask

   initial begin
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      t_reset();
      t_write_update();
      t_broadcast();
      t_bad_frames();
      t_power();
      t_hold();
      t_config();
      t_ignored();
      t_zero_and_reset();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule